// File: doc/BRIEF.md
# Configurable Routing-and-Logic Tile

This block is a single cell of an island-style programmable fabric. A flat configuration word, held stable by the surrounding fabric, sets everything the tile does. Four input selectors each pick one of these sources: a routing track, the tile's own fed-back result, a constant, or the result of an adjacent tile. The four picked bits address a 16-entry truth table.

The table output feeds three things. It drives a one-stage ripple-carry slice. It feeds a flip-flop that samples it on every clock edge. It also feeds the result selector that forms the tile's logic output. For each routing direction and each track, a small gated selector chooses what the tile drives onto that track: the logic output, the same track arriving from one of the other three sides, or nothing.

The track count per side is the parameter `TRACKS`. The word width and every field position follow from it. The surrounding grid ties neighbour inputs to 0 at the edge of the fabric, so those inputs read as 0 there.

Top module: `fabric_tile`

## Requirements
- R1: With W = ceil(log2(4*TRACKS+7)), the configuration word is 18 + 4*W + 16*TRACKS bits wide, which is 50 bits for TRACKS=1. The fields sit as follows:
  - bits [15:0] hold the truth table;
  - bit 16 is the carry-mode flag;
  - bit 17 is the register-select flag;
  - input selector k (k=0..3) is the W bits at 18+k*W;
  - the driver field for side d (0=N, 1=E, 2=S, 3=W) and track t is the 4 bits at 18+4*W+4*(d*TRACKS+t), with the enable at its lowest bit and a 3-bit source code above it.
- R2: An input selector code below 4*TRACKS picks side (code / TRACKS), track (code mod TRACKS), with the sides ordered N=0, E=1, S=2, W=3.
- R3: Code 4*TRACKS picks the tile's own logic output as it was one clock earlier. This value is 0 in the first cycle after reset.
- R4: Code 4*TRACKS+1 gives 0 and code 4*TRACKS+2 gives 1. Every code above 4*TRACKS+6 gives 0.
- R5: Codes 4*TRACKS+3 to 4*TRACKS+6 pick the neighbour result input bits 0 to 3, which are the N, E, S and W neighbours.
- R6: The table output is table bit {in3,in2,in1,in0}. When both flags are 0, the logic output equals this value combinationally.
- R7: When carry mode is set, the logic output is the table output XOR the carry input, whatever the register flag says. The carry output is always the majority of in0, in1 and the carry input.
- R8: The flip-flop samples the table output on every clock edge, whatever the flags say. With the register flag set and carry mode clear, the logic output is the flip-flop value.
- R9: A synchronous active-low reset clears the flip-flop and the feedback register to 0.
- R10: A driver whose enable bit is 0 drives 0.
- R11: An enabled driver on side d uses its 3-bit source code as follows:
  - 0 drives the logic output;
  - k = 1..3 drives the same track arriving from side (d+k) mod 4;
  - codes 4 to 7 drive 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tile clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 18+4*W+16*TRACKS | Configuration word |
| trk_n_i | input | TRACKS | Tracks arriving from the north |
| trk_e_i | input | TRACKS | Tracks arriving from the east |
| trk_s_i | input | TRACKS | Tracks arriving from the south |
| trk_w_i | input | TRACKS | Tracks arriving from the west |
| nbr_res_i | input | 4 | Adjacent tile results, bit 0=N, 1=E, 2=S, 3=W |
| carry_i | input | 1 | Carry from the previous slice |
| carry_o | output | 1 | Carry to the next slice |
| res_o | output | 1 | Tile logic output |
| trk_n_o | output | TRACKS | Tracks driven to the north |
| trk_e_o | output | TRACKS | Tracks driven to the east |
| trk_s_o | output | TRACKS | Tracks driven to the south |
| trk_w_o | output | TRACKS | Tracks driven to the west |

## Verification
The assertions take the configuration word to be static between clock edges. They also take every input to be settled at the sampling edge, so the relation between selector code and picked value holds at that edge. The flip-flop check also assumes that the table output one edge earlier came from a cycle out of reset. The stimulus changes configuration and tracks only just after a falling edge and holds them until after the next rising edge, and it starts with reset asserted. The tile's own feedback path is the only loop it closes, and that path is registered, so no combinational cycle is ever formed.

// File: rtl/tile_pkg.sv
// Shared layout constants and field-offset functions for the fabric tile.
// Assumes: the word layout is fixed part, four input selectors, then
// per-side per-track driver fields, all derived from the track count.
package tile_pkg;
    localparam int FIX_W     = 18;
    localparam int TBL_W     = 16;
    localparam int CARRY_BIT = 16;
    localparam int REG_BIT   = 17;
    localparam int NUM_IN    = 4;
    localparam int NUM_SIDE  = 4;
    localparam int SRC_W     = 3;
    localparam int DRV_W     = 1 + SRC_W;

    typedef enum int {SIDE_N = 0, SIDE_E = 1, SIDE_S = 2, SIDE_W = 3} side_e;

    function automatic int sel_width(input int t);
        return $clog2(4 * t + 7);
    endfunction

    function automatic int cfg_width(input int t);
        return FIX_W + NUM_IN * sel_width(t) + NUM_SIDE * t * DRV_W;
    endfunction

    function automatic int in_sel_off(input int k, input int t);
        return FIX_W + k * sel_width(t);
    endfunction

    function automatic int drv_off(input int d, input int tr, input int t);
        return FIX_W + NUM_IN * sel_width(t) + (d * t + tr) * DRV_W;
    endfunction
endpackage

// File: rtl/tile_in_sel.sv
// One input selector of the tile. It decodes a selector code into a track,
// the registered own result, a constant or an adjacent tile's result.
// Assumes: trk_flat is ordered side*TRACKS+track with N,E,S,W sides.
module tile_in_sel #(
    parameter int TRACKS = 1,
    parameter int SW     = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [4*TRACKS-1:0]   trk_flat,
    input  logic [3:0]            nbr,
    input  logic                  fb,
    input  logic [SW-1:0]         sel,
    output logic                  val
);
    localparam int TW = 4 * TRACKS;

    // Decode the selector code; codes without a source fall to 0.
    always_comb begin
        val = 1'b0;
        for (int i = 0; i < TW; i++) begin
            if (sel == SW'(i)) val = trk_flat[i];
        end
        if (sel == SW'(TW))     val = fb;
        if (sel == SW'(TW + 2)) val = 1'b1;
        for (int d = 0; d < 4; d++) begin
            if (sel == SW'(TW + 3 + d)) val = nbr[d];
        end
    end

    // R4
    r4_const_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SW'(TW + 2)) |-> val);
    // R4
    r4_const_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SW'(TW + 1)) |-> !val);
    // R4
    r4_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel > SW'(TW + 6)) |-> !val);

    for (genvar d = 0; d < 4; d++) begin : g_nb
        // R5
        r5_nbr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel == SW'(TW + 3 + d)) |-> (val == nbr[d]));
    end
endmodule

// File: rtl/tile_logic.sv
// Logic core of the tile: 16-entry truth table, carry slice, flip-flop,
// result selector and a registered copy of the result for feedback.
// Assumes: the flags and table are static configuration.
module tile_logic (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  ins,
    input  logic [15:0] table_bits,
    input  logic        carry_mode,
    input  logic        reg_sel,
    input  logic        carry_i,
    output logic        tbl_o,
    output logic        res_o,
    output logic        carry_o,
    output logic        fb_o
);
    logic ff_q;

    // Table lookup addressed by the four selected inputs.
    assign tbl_o = table_bits[ins];

    // Carry generate / propagate over in0, in1 and the incoming carry.
    assign carry_o = (ins[0] & ins[1]) | (carry_i & (ins[0] ^ ins[1]));

    // Flip-flop always samples the table output.
    always_ff @(posedge clk) begin
        if (!rst_n) ff_q <= 1'b0;
        else        ff_q <= tbl_o;
    end

    // Result priority: carry sum, then register, then table.
    always_comb begin
        if (carry_mode)   res_o = tbl_o ^ carry_i;
        else if (reg_sel) res_o = ff_q;
        else              res_o = tbl_o;
    end

    // Registered copy of the result for the own-feedback selector code.
    always_ff @(posedge clk) begin
        if (!rst_n) fb_o <= 1'b0;
        else        fb_o <= res_o;
    end

    // R7
    r7_carry_maj_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o == ($countones({ins[0], ins[1], carry_i}) >= 2));
    // R9
    r9_ff_reset_chk: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> (ff_q == 1'b0 && fb_o == 1'b0));
endmodule

// File: rtl/tile_drv.sv
// One gated track driver: with its enable set it forwards the tile result
// or the same track from one of the other three sides, else drives 0.
// Assumes: other[k-1] is the track arriving from side (own+k) mod 4.
module tile_drv (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [2:0] src,
    input  logic       res,
    input  logic [2:0] other,
    output logic       drv
);
    // Gated source selection; codes 4..7 drive 0.
    always_comb begin
        drv = 1'b0;
        if (en) begin
            case (src)
                3'd0:    drv = res;
                3'd1:    drv = other[0];
                3'd2:    drv = other[1];
                3'd3:    drv = other[2];
                default: drv = 1'b0;
            endcase
        end
    end

    // R10
    r10_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !drv);
    // R11
    r11_unused_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src[2] |-> !drv);
endmodule

// File: rtl/fabric_tile.sv
// Top of one programmable fabric tile. It slices the configuration word
// into fields, builds four input selectors, the logic core and one gated
// driver per side and track.
// Assumes: cfg_word is static between edges; edge neighbours are tied to 0.
module fabric_tile
    import tile_pkg::*;
#(
    parameter int TRACKS = 1,
    localparam int SW    = sel_width(TRACKS),
    localparam int CFG_W = cfg_width(TRACKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [TRACKS-1:0] trk_n_i,
    input  logic [TRACKS-1:0] trk_e_i,
    input  logic [TRACKS-1:0] trk_s_i,
    input  logic [TRACKS-1:0] trk_w_i,
    input  logic [3:0]        nbr_res_i,
    input  logic              carry_i,
    output logic              carry_o,
    output logic              res_o,
    output logic [TRACKS-1:0] trk_n_o,
    output logic [TRACKS-1:0] trk_e_o,
    output logic [TRACKS-1:0] trk_s_o,
    output logic [TRACKS-1:0] trk_w_o
);
    localparam int TW = 4 * TRACKS;

    logic [TW-1:0] trk_flat;
    logic [TW-1:0] out_flat;
    logic [3:0]    ins;
    logic          tbl_w;
    logic          fb_w;
    logic          carry_mode;
    logic          reg_sel;

    // Incoming tracks flattened as side*TRACKS+track, sides N,E,S,W.
    assign trk_flat   = {trk_w_i, trk_s_i, trk_e_i, trk_n_i};
    assign carry_mode = cfg_word[CARRY_BIT];
    assign reg_sel    = cfg_word[REG_BIT];

    for (genvar k = 0; k < NUM_IN; k++) begin : g_in
        tile_in_sel #(.TRACKS(TRACKS), .SW(SW)) u_sel (
            .clk      (clk),
            .rst_n    (rst_n),
            .trk_flat (trk_flat),
            .nbr      (nbr_res_i),
            .fb       (fb_w),
            .sel      (cfg_word[in_sel_off(k, TRACKS) +: SW]),
            .val      (ins[k])
        );
    end

    tile_logic u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins        (ins),
        .table_bits (cfg_word[TBL_W-1:0]),
        .carry_mode (carry_mode),
        .reg_sel    (reg_sel),
        .carry_i    (carry_i),
        .tbl_o      (tbl_w),
        .res_o      (res_o),
        .carry_o    (carry_o),
        .fb_o       (fb_w)
    );

    for (genvar d = 0; d < NUM_SIDE; d++) begin : g_side
        for (genvar t = 0; t < TRACKS; t++) begin : g_trk
            localparam int OFF = drv_off(d, t, TRACKS);
            logic [2:0] other;
            for (genvar k = 1; k < 4; k++) begin : g_oth
                assign other[k-1] = trk_flat[((d + k) % 4) * TRACKS + t];
            end
            tile_drv u_drv (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (cfg_word[OFF]),
                .src   (cfg_word[OFF+1 +: SRC_W]),
                .res   (res_o),
                .other (other),
                .drv   (out_flat[d*TRACKS+t])
            );
        end
    end

    // Outgoing tracks split back per side.
    assign trk_n_o = out_flat[SIDE_N*TRACKS +: TRACKS];
    assign trk_e_o = out_flat[SIDE_E*TRACKS +: TRACKS];
    assign trk_s_o = out_flat[SIDE_S*TRACKS +: TRACKS];
    assign trk_w_o = out_flat[SIDE_W*TRACKS +: TRACKS];

    // R7
    r7_carry_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_mode |-> (res_o == (tbl_w ^ carry_i)));
    // R8
    r8_reg_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !carry_mode && reg_sel && $stable(cfg_word))
        |-> (res_o == $past(tbl_w)));
endmodule

// File: tb/sim_fabric_tile.sv
// Directed bench for fabric_tile with TRACKS=1 against a requirement model.
module sim_fabric_tile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [49:0] cfg = '0;
    logic        tn = 0, te = 0, ts = 0, tw = 0;
    logic [3:0]  nb = '0;
    logic        cin = 1'b0;
    logic        cout, res;
    logic        on, oe, os, ow;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    fabric_tile #(.TRACKS(1)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg),
        .trk_n_i(tn), .trk_e_i(te), .trk_s_i(ts), .trk_w_i(tw),
        .nbr_res_i(nb), .carry_i(cin), .carry_o(cout), .res_o(res),
        .trk_n_o(on), .trk_e_o(oe), .trk_s_o(os), .trk_w_o(ow)
    );

    // ---------------- requirement model ----------------
    logic m_ff = 1'b0, m_fb = 1'b0;

    // R2..R5: input selector decode for TRACKS=1.
    function automatic logic pick(input logic [3:0] c, input logic [8:0] v);
        case (c)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4: return v[c];
            4'd6:                         return 1'b1;
            4'd7, 4'd8, 4'd9, 4'd10:      return v[c-2];
            default:                      return 1'b0;
        endcase
    endfunction

    // R10/R11: gated driver model.
    function automatic logic opick(input int d, input logic en, input logic [2:0] s,
                                   input logic r, input logic [3:0] trk);
        if (!en) return 1'b0;
        if (s == 0) return r;
        if (s <= 3) return trk[(d + int'(s)) % 4];
        return 1'b0;
    endfunction

    logic [8:0]  srcv;
    logic [3:0]  e_in;
    logic [15:0] e_tbl_bits;
    logic        e_tbl, e_res, e_cout;
    logic [3:0]  e_out;
    assign srcv       = {nb, m_fb, tw, ts, te, tn};
    assign e_in[0]    = pick(cfg[21:18], srcv);
    assign e_in[1]    = pick(cfg[25:22], srcv);
    assign e_in[2]    = pick(cfg[29:26], srcv);
    assign e_in[3]    = pick(cfg[33:30], srcv);
    assign e_tbl_bits = cfg[15:0];
    assign e_tbl      = e_tbl_bits[e_in];
    assign e_res      = cfg[16] ? (e_tbl ^ cin) : (cfg[17] ? m_ff : e_tbl);
    assign e_cout     = (e_in[0] & e_in[1]) | (cin & (e_in[0] | e_in[1]));
    assign e_out[0]   = opick(0, cfg[34], cfg[37:35], e_res, {tw, ts, te, tn});
    assign e_out[1]   = opick(1, cfg[38], cfg[41:39], e_res, {tw, ts, te, tn});
    assign e_out[2]   = opick(2, cfg[42], cfg[45:43], e_res, {tw, ts, te, tn});
    assign e_out[3]   = opick(3, cfg[46], cfg[49:47], e_res, {tw, ts, te, tn});

    // R8/R9/R3: model state updated at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ff <= 1'b0;
            m_fb <= 1'b0;
        end else begin
            m_ff <= e_tbl;
            m_fb <= e_res;
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [49:0] mk(input logic [15:0] tbl, input logic cm, input logic rs,
                                       input logic [3:0] s0, input logic [3:0] s1,
                                       input logic [3:0] s2, input logic [3:0] s3,
                                       input logic [3:0] oen, input logic [11:0] osrc);
        logic [49:0] c;
        c = '0;
        c[15:0] = tbl; c[16] = cm; c[17] = rs;
        c[21:18] = s0; c[25:22] = s1; c[29:26] = s2; c[33:30] = s3;
        for (int d = 0; d < 4; d++) begin
            c[34 + 4*d] = oen[d];
            c[35 + 4*d +: 3] = osrc[3*d +: 3];
        end
        return c;
    endfunction

    task automatic expect1(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // Compare every output against the model.
    task automatic chk_all(input string tag);
        expect1(tag, "res_o", res, e_res);
        expect1(tag, "carry_o", cout, e_cout);
        expect1(tag, "trk_o", (on == e_out[0]) && (oe == e_out[1]) &&
                (os == e_out[2]) && (ow == e_out[3]), 1'b1);
    endtask

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        // R9: register flag set, table constant 1, held in reset.
        cfg = mk(16'hFFFF, 0, 1, 4'd6, 4'd6, 4'd6, 4'd6, 4'hF, 12'h000);
        repeat (3) step();
        expect1("R9", "res_o in reset", res, 1'b0);
        chk_all("R9");
        @(negedge clk); rst_n = 1'b1; #2;
        expect1("R9", "res_o first cycle", res, 1'b0);
        step();
        expect1("R8", "res_o after edge", res, 1'b1);
    endtask

    task automatic t_table();
        // R6: AND of four tracks; sweep all input patterns.
        cfg = mk(16'h8000, 0, 0, 4'd0, 4'd1, 4'd2, 4'd3, 4'h0, 12'h000);
        for (int v = 0; v < 16; v++) begin
            step();
            {tw, ts, te, tn} = v[3:0]; #1;
            expect1("R6", "and4", res, (v == 15));
            chk_all("R6");
        end
        // R6: arbitrary table with inputs rotated.
        cfg = mk(16'h6C3A, 0, 0, 4'd3, 4'd0, 4'd2, 4'd1, 4'h0, 12'h000);
        for (int v = 0; v < 16; v++) begin
            step();
            {tw, ts, te, tn} = v[3:0]; #1;
            chk_all("R6");
        end
    endtask

    task automatic t_tracks();
        // R2: in0 pass-through table, selector walks over the four sides.
        for (int c = 0; c < 4; c++) begin
            cfg = mk(16'hAAAA, 0, 0, 4'(c), 4'd5, 4'd5, 4'd5, 4'h0, 12'h000);
            for (int v = 0; v < 4; v++) begin
                step();
                {tw, ts, te, tn} = 4'(1 << v); #1;
                expect1("R2", "track pick", res, (v == c));
            end
        end
    endtask

    task automatic t_consts();
        // R4: constants and unused codes with every source high.
        {tw, ts, te, tn} = 4'hF; nb = 4'hF;
        cfg = mk(16'hAAAA, 0, 0, 4'd5, 4'd0, 4'd0, 4'd0, 4'h0, 12'h000); step();
        expect1("R4", "const0", res, 1'b0);
        cfg = mk(16'hAAAA, 0, 0, 4'd6, 4'd5, 4'd5, 4'd5, 4'h0, 12'h000);
        {tw, ts, te, tn} = 4'h0; nb = 4'h0; step();
        expect1("R4", "const1", res, 1'b1);
        {tw, ts, te, tn} = 4'hF; nb = 4'hF;
        for (int c = 11; c < 16; c++) begin
            cfg = mk(16'hAAAA, 0, 0, 4'(c), 4'd0, 4'd0, 4'd0, 4'h0, 12'h000); step();
            expect1("R4", "unused code", res, 1'b0);
        end
        nb = 4'h0;
    endtask

    task automatic t_nbr();
        // R5: neighbour codes 7..10 map to N,E,S,W neighbour bits.
        {tw, ts, te, tn} = 4'h0;
        for (int d = 0; d < 4; d++) begin
            cfg = mk(16'hAAAA, 0, 0, 4'(7 + d), 4'd5, 4'd5, 4'd5, 4'h0, 12'h000);
            for (int v = 0; v < 4; v++) begin
                step();
                nb = 4'(1 << v); #1;
                expect1("R5", "neighbour pick", res, (v == d));
            end
        end
        nb = 4'h0;
    endtask

    task automatic t_feedback();
        // R3: in0 from own fed-back result, table inverts in0 -> toggles.
        cfg = mk(16'h5555, 0, 0, 4'd4, 4'd5, 4'd5, 4'd5, 4'h0, 12'h000);
        step();
        for (int i = 0; i < 6; i++) begin
            logic prev;
            prev = res;
            step();
            expect1("R3", "toggle", res, ~prev);
            chk_all("R3");
        end
    endtask

    task automatic t_carry();
        // R7: xor table on in0/in1 with carry mode and register flag both set.
        cfg = mk(16'h6666, 1, 1, 4'd0, 4'd1, 4'd5, 4'd5, 4'h0, 12'h000);
        for (int v = 0; v < 8; v++) begin
            step();
            {cin, te, tn} = v[2:0]; #1;
            expect1("R7", "sum", res, ^v[2:0]);
            expect1("R7", "carry", cout, ($countones(v[2:0]) >= 2));
        end
        cin = 1'b0;
    endtask

    task automatic t_reg();
        // R8: register flag, table passes in0; result lags the track by one edge.
        {tw, ts, te, tn} = 4'h0;
        cfg = mk(16'hAAAA, 0, 1, 4'd0, 4'd5, 4'd5, 4'd5, 4'h0, 12'h000);
        step(); step();
        tn = 1'b1; #1;
        expect1("R8", "before edge", res, 1'b0);
        step();
        expect1("R8", "after edge", res, 1'b1);
        tn = 1'b0; #1;
        expect1("R8", "holds", res, 1'b1);
        // R8: flip-flop kept sampling while register flag was clear.
        cfg = mk(16'hAAAA, 0, 0, 4'd0, 4'd5, 4'd5, 4'd5, 4'h0, 12'h000);
        tn = 1'b1; step(); step();
        cfg = mk(16'hAAAA, 0, 1, 4'd0, 4'd5, 4'd5, 4'd5, 4'h0, 12'h000);
        tn = 1'b0; #1;
        expect1("R8", "sampled while bypassed", res, 1'b1);
        step();
    endtask

    task automatic t_drivers();
        // R10: drivers disabled with result 1 and sources high.
        {tw, ts, te, tn} = 4'hF;
        cfg = mk(16'hFFFF, 0, 0, 4'd6, 4'd6, 4'd6, 4'd6, 4'h0, 12'h000); step();
        expect1("R10", "disabled", on | oe | os | ow, 1'b0);
        // R11: each source code on every side, with varied track values.
        for (int s = 0; s < 8; s++) begin
            for (int v = 0; v < 16; v += 5) begin
                cfg = mk(16'h0000, 0, 0, 4'd5, 4'd5, 4'd5, 4'd5, 4'hF,
                         {3'(s), 3'(s), 3'(s), 3'(s)});
                step();
                {tw, ts, te, tn} = v[3:0]; #1;
                chk_all("R11");
            end
        end
        // R1: only the west enable bit (46) set, source 0, table constant 1.
        cfg = mk(16'hFFFF, 0, 0, 4'd5, 4'd5, 4'd5, 4'd5, 4'b1000, 12'h000); step();
        expect1("R1", "west only", {ow, os, oe, on} == 4'b1000, 1'b1);
        expect1("R1", "width", ($bits(cfg) == 50), 1'b1);
    endtask

    initial begin
        t_reset();
        t_table();
        t_tracks();
        t_consts();
        t_nbr();
        t_feedback();
        t_carry();
        t_reg();
        t_drivers();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule